// File: doc/BRIEF.md
# Keyboard Command Transmitter (host side)

This block sends a short command word from the host to a keyboard over a three-wire link. The host owns a data line and a strobe line, both high at rest. The keyboard owns one return line that says "ready" when high and later carries the acknowledge and the parity verdict. Firmware or a neighbouring controller loads a command, pulses `start`, and later sees `done` together with two result flags.

A transfer goes through these steps. The block first waits, with a bounded timeout, for the keyboard's line to go high. It then interrupts the keyboard by pulling both host lines low. After a fixed delay it checks that the keyboard has answered by pulling its line low. It then shifts out the command bits, most significant first, followed by an odd parity bit. Each bit is framed by one high strobe phase and one low strobe phase, and the keyboard samples the bit when the strobe falls. A final high strobe phase asks the keyboard for its verdict. A low strobe phase then closes the transfer, and the strobe returns high.

The keyboard's line is asynchronous, so it passes through a synchronizer before the control logic uses it. All delays are counted in clock cycles and set by parameters. The defaults assume a 200 MHz clock: a 100 ms readiness timeout, a 70 µs acknowledge delay and 10 µs strobe phases.

Top module: `kbd_cmd_tx`

## Requirements
- R1: After reset, and whenever `busy` is low, `host_data` and `host_strobe` are high. After reset, `busy`, `done`, `kb_err` and `par_err` are low.
- R2: When `busy` is low, a high `start` captures `cmd` and `busy` rises on the next cycle. A `start` while `busy` is high is ignored, and the command being sent is not changed.
- R3: The block waits for the synchronized `kb_line` to be high. If the line stays low for READY_TO_CYC cycles, the block ends with `kb_err` = 1. In that case `busy` stays high for exactly READY_TO_CYC cycles.
- R4: Once the keyboard is ready, `host_data` and `host_strobe` go low together for ACK_CYC cycles. At the end of that window the synchronized `kb_line` is sampled. If it is still high, the block ends with `kb_err` = 1, after 1 + ACK_CYC busy cycles.
- R5: The frame holds CMD_W + 1 bits: `cmd[CMD_W-1]` first, down to `cmd[0]`, then the parity bit. Each bit is driven on `host_data` for one high strobe phase of PHASE_CYC cycles and one low strobe phase of PHASE_CYC cycles. `host_data` stays steady across the falling strobe edge.
- R6: The parity bit makes the total count of ones in the command bits and the parity bit odd.
- R7: After the last bit, the strobe is high for PHASE_CYC cycles, and the synchronized `kb_line` is sampled at the end of that phase. If it is low, `par_err` = 1. If it is high, `par_err` = 0.
- R8: A transfer ends with a low strobe phase of PHASE_CYC cycles, after which the strobe returns high. A complete transfer lasts 1 + ACK_CYC + (2·(CMD_W+1)+2)·PHASE_CYC busy cycles. `done` is high for one cycle, at the first idle cycle after any ending. `kb_err` and `par_err` keep their values until the next accepted `start`.
- R9: `kb_err` and `par_err` are never high together, and an accepted `start` clears both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer (taken only when idle) |
| cmd | input | CMD_W | Command word to send |
| kb_line | input | 1 | Keyboard's ready / acknowledge / verdict line (asynchronous) |
| host_data | output | 1 | Host data line to the keyboard |
| host_strobe | output | 1 | Host strobe line to the keyboard |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse when a transfer ends |
| kb_err | output | 1 | Keyboard not ready in time or did not acknowledge |
| par_err | output | 1 | Keyboard reported a parity error |

## Verification
The hardest cases to reach are those where the keyboard misbehaves partway through a transfer: it acknowledges and then rejects the parity, it never drops its line after the interrupt, or it becomes ready only after the timeout counter has started. The bench uses a behavioural keyboard model that follows the strobe edges. Its ready level, its acknowledge and its verdict can each be switched per transfer. The model also measures every strobe phase and collects the bits at the falling edges, so the frame content and the timing are checked for all 32 command values.

// File: rtl/kbd_cmd_pkg.sv
package kbd_cmd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_INTR,
        ST_BHI,
        ST_BLO,
        ST_VHI,
        ST_ELO
    } tx_state_e;

endpackage

// File: rtl/kbd_cmd_sync.sv
module kbd_cmd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] ff_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) ff_q <= '0;
                else        ff_q <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) ff_q <= '0;
                else        ff_q <= {ff_q[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = ff_q[STAGES-1];
endmodule

// File: rtl/kbd_cmd_timer.sv
module kbd_cmd_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         expired
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)              cnt_d = val;
        else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/kbd_cmd_parity.sv
module kbd_cmd_parity #(
    parameter int W = 5
) (
    input  logic [W-1:0] data,
    output logic         odd_bit
);
    logic [W:0] acc;

    assign acc[0] = 1'b1;
    generate
        for (genvar i = 0; i < W; i++) begin : g_xor
            assign acc[i+1] = acc[i] ^ data[i];
        end
    endgenerate

    assign odd_bit = acc[W];
endmodule

// File: rtl/kbd_cmd_tx.sv
module kbd_cmd_tx
    import kbd_cmd_pkg::*;
#(
    parameter int CMD_W        = 5,
    parameter int READY_TO_CYC = 20_000_000,
    parameter int ACK_CYC      = 14_000,
    parameter int PHASE_CYC    = 2_000,
    parameter int SYNC_STAGES  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CMD_W-1:0] cmd,
    input  logic             kb_line,
    output logic             host_data,
    output logic             host_strobe,
    output logic             busy,
    output logic             done,
    output logic             kb_err,
    output logic             par_err
);
    localparam int FRAME_W = CMD_W + 1;
    localparam int T_MAX   = (READY_TO_CYC > ACK_CYC)
                           ? ((READY_TO_CYC > PHASE_CYC) ? READY_TO_CYC : PHASE_CYC)
                           : ((ACK_CYC > PHASE_CYC) ? ACK_CYC : PHASE_CYC);
    localparam int TW      = $clog2(T_MAX + 1);
    localparam int BW      = $clog2(FRAME_W + 1);

    localparam logic [TW-1:0] T_RDY   = TW'(READY_TO_CYC - 1);
    localparam logic [TW-1:0] T_ACK   = TW'(ACK_CYC - 1);
    localparam logic [TW-1:0] T_PHASE = TW'(PHASE_CYC - 1);
    localparam logic [BW-1:0] LAST_B  = BW'(FRAME_W - 1);

    typedef struct packed {
        tx_state_e          st;
        logic [FRAME_W-1:0] sh;
        logic [BW-1:0]      bcnt;
        logic               done;
        logic               kb_err;
        logic               par_err;
    } tx_regs_t;

    tx_regs_t        r_d, r_q;
    logic            line_s;
    logic            par_bit;
    logic            t_load;
    logic [TW-1:0]   t_val;
    logic            t_exp;

    kbd_cmd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (kb_line),
        .q     (line_s)
    );

    kbd_cmd_parity #(.W(CMD_W)) u_par (
        .data    (cmd),
        .odd_bit (par_bit)
    );

    kbd_cmd_timer #(.W(TW)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (t_load),
        .val     (t_val),
        .expired (t_exp)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        t_load   = 1'b0;
        t_val    = '0;
        case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.st      = ST_WAIT;
                    r_d.sh      = {cmd, par_bit};
                    r_d.bcnt    = '0;
                    r_d.kb_err  = 1'b0;
                    r_d.par_err = 1'b0;
                    t_load      = 1'b1;
                    t_val       = T_RDY;
                end
            end
            ST_WAIT: begin
                if (line_s) begin
                    r_d.st = ST_INTR;
                    t_load = 1'b1;
                    t_val  = T_ACK;
                end else if (t_exp) begin
                    r_d.st     = ST_IDLE;
                    r_d.kb_err = 1'b1;
                    r_d.done   = 1'b1;
                end
            end
            ST_INTR: begin
                if (t_exp) begin
                    if (line_s) begin
                        r_d.st     = ST_IDLE;
                        r_d.kb_err = 1'b1;
                        r_d.done   = 1'b1;
                    end else begin
                        r_d.st = ST_BHI;
                        t_load = 1'b1;
                        t_val  = T_PHASE;
                    end
                end
            end
            ST_BHI: begin
                if (t_exp) begin
                    r_d.st = ST_BLO;
                    t_load = 1'b1;
                    t_val  = T_PHASE;
                end
            end
            ST_BLO: begin
                if (t_exp) begin
                    r_d.sh   = {r_q.sh[FRAME_W-2:0], 1'b0};
                    r_d.bcnt = r_q.bcnt + 1'b1;
                    r_d.st   = (r_q.bcnt == LAST_B) ? ST_VHI : ST_BHI;
                    t_load   = 1'b1;
                    t_val    = T_PHASE;
                end
            end
            ST_VHI: begin
                if (t_exp) begin
                    r_d.par_err = ~line_s;
                    r_d.st      = ST_ELO;
                    t_load      = 1'b1;
                    t_val       = T_PHASE;
                end
            end
            ST_ELO: begin
                if (t_exp) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st      <= ST_IDLE;
            r_q.sh      <= '0;
            r_q.bcnt    <= '0;
            r_q.done    <= 1'b0;
            r_q.kb_err  <= 1'b0;
            r_q.par_err <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        host_data = 1'b1;
        if (r_q.st == ST_INTR)
            host_data = 1'b0;
        else if (r_q.st == ST_BHI || r_q.st == ST_BLO)
            host_data = r_q.sh[FRAME_W-1];
    end

    assign host_strobe = !(r_q.st == ST_INTR || r_q.st == ST_BLO || r_q.st == ST_ELO);
    assign busy        = (r_q.st != ST_IDLE);
    assign done        = r_q.done;
    assign kb_err      = r_q.kb_err;
    assign par_err     = r_q.par_err;
endmodule

// File: rtl/kbd_cmd_tx_chk.sv
module kbd_cmd_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic done,
    input logic host_data,
    input logic host_strobe,
    input logic kb_err,
    input logic par_err
);
    // R1
    idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (host_data && host_strobe));

    // R2
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R8
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(kb_err) && $stable(par_err)));

    // R9
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(kb_err && par_err));
endmodule

bind kbd_cmd_tx kbd_cmd_tx_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .busy        (busy),
    .done        (done),
    .host_data   (host_data),
    .host_strobe (host_strobe),
    .kb_err      (kb_err),
    .par_err     (par_err)
);

// File: tb/kbd_cmd_tx_tb.sv
`timescale 1ns/1ps
module kbd_cmd_tx_tb;
    localparam int CW  = 5;
    localparam int RDY = 50;
    localparam int ACK = 8;
    localparam int PH  = 4;
    localparam int FULL = 1 + ACK + (2 * (CW + 1) + 2) * PH;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [CW-1:0] cmd = '0;
    logic          kb_line;
    logic          host_data, host_strobe, busy, done, kb_err, par_err;

    int n_chk = 0;
    int n_err = 0;

    // keyboard model controls
    logic ready_lvl = 1'b1;
    logic ack_en    = 1'b1;
    logic bad_ver   = 1'b0;
    // keyboard model state
    int         m_phase = 0;
    logic       m_prev = 1'b1;
    int         m_run = 0;
    int         m_bits = 0;
    int         m_rises = 0;
    int         m_wbad = 0;
    logic [5:0] m_rx = '0;

    always #2.5 clk = ~clk;

    kbd_cmd_tx #(
        .CMD_W(CW), .READY_TO_CYC(RDY), .ACK_CYC(ACK), .PHASE_CYC(PH), .SYNC_STAGES(2)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd), .kb_line(kb_line),
        .host_data(host_data), .host_strobe(host_strobe), .busy(busy),
        .done(done), .kb_err(kb_err), .par_err(par_err)
    );

    always @(negedge clk) begin
        if (!rst_n || !busy) begin
            m_phase = 0;
            kb_line = ready_lvl;
            m_prev  = host_strobe;
            m_run   = 1;
        end else if (m_phase == 0) begin
            kb_line = ready_lvl;
            if (!host_data && !host_strobe) begin
                m_phase = 1; m_bits = 0; m_rx = '0; m_rises = 0;
                if (ack_en) kb_line = 1'b0;
            end
            m_prev = host_strobe;
            m_run  = 1;
        end else begin
            if (host_strobe == m_prev) begin
                m_run++;
            end else begin
                if (m_phase == 1) begin
                    if (!host_strobe) begin
                        if (m_run != PH) m_wbad++;
                        if (m_bits < 6) begin
                            m_rx = {m_rx[4:0], host_data};
                            m_bits++;
                        end
                    end else begin
                        if ((m_rises == 0) ? (m_run != ACK) : (m_run != PH)) m_wbad++;
                        m_rises++;
                        if (m_bits == 6) begin
                            kb_line = (^m_rx) && !bad_ver;
                            m_phase = 2;
                        end
                    end
                end else if (m_phase == 2 && !host_strobe) begin
                    kb_line = 1'b0;
                    m_phase = 3;
                end
                m_run = 1;
            end
            m_prev = host_strobe;
        end
    end

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // runs one transfer; returns busy cycle count
    task automatic xfer(input logic [CW-1:0] c, input int rdy_after, input logic poke,
                        output int nbusy);
        int n;
        n = 0;
        @(negedge clk);
        start = 1'b1; cmd = c;
        @(negedge clk);
        start = 1'b0;
        chk(!kb_err && !par_err, "R9 flags cleared on start", {kb_err, par_err}, 0);
        chk(busy, "R2 busy after start", busy, 1);
        while (!done && n < 5000) begin
            if (busy) n++;
            if (rdy_after >= 0 && n == rdy_after) ready_lvl = 1'b1;
            if (poke && n == 3) begin start = 1'b1; cmd = ~c; end
            else start = 1'b0;
            @(negedge clk);
        end
        start = 1'b0;
        nbusy = n;
    endtask

    initial begin
        int nb;
        int wb0;
        logic [5:0] exp_fr;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(host_data && host_strobe && !busy && !done && !kb_err && !par_err,
            "R1 reset state", {host_data, host_strobe, busy, done, kb_err, par_err}, 6'b110000);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R5 R6 R7 R8: sweep all commands, good verdict
        for (int c = 0; c < 32; c++) begin
            wb0 = m_wbad;
            xfer(CW'(c), -1, 1'b0, nb);
            exp_fr = {CW'(c), ~^CW'(c)};
            chk(m_rx == exp_fr, "R5 frame bits", int'(m_rx), int'(exp_fr));
            chk(^m_rx == 1'b1, "R6 odd parity", int'(^m_rx), 1);
            chk(m_wbad == wb0, "R5 strobe phase widths", m_wbad - wb0, 0);
            chk(done && !kb_err && !par_err, "R7 good verdict", {done, kb_err, par_err}, 3'b100);
            chk(nb == FULL, "R8 transfer length", nb, FULL);
            @(negedge clk);
            chk(!done, "R8 done one cycle", done, 0);
            repeat (2) @(negedge clk);
        end

        // R7 rejected parity
        bad_ver = 1'b1;
        for (int c = 0; c < 32; c += 7) begin
            xfer(CW'(c), -1, 1'b0, nb);
            chk(par_err && !kb_err, "R7 parity error reported", {kb_err, par_err}, 2'b01);
            repeat (5) @(negedge clk);
            chk(par_err && host_strobe && host_data, "R8 flag held, lines idle R1",
                {par_err, host_strobe, host_data}, 3'b111);
        end
        bad_ver = 1'b0;

        // R4 no acknowledge
        ack_en = 1'b0;
        xfer(5'h15, -1, 1'b0, nb);
        chk(kb_err && !par_err, "R4 missing ack error", {kb_err, par_err}, 2'b10);
        chk(nb == 1 + ACK, "R4 ack window length", nb, 1 + ACK);
        ack_en = 1'b1;
        repeat (3) @(negedge clk);

        // R3 never ready
        ready_lvl = 1'b0;
        repeat (4) @(negedge clk);
        xfer(5'h0A, -1, 1'b0, nb);
        chk(kb_err && !par_err, "R3 ready timeout error", {kb_err, par_err}, 2'b10);
        chk(nb == RDY, "R3 timeout length", nb, RDY);
        repeat (3) @(negedge clk);

        // R3 late ready within the window
        xfer(5'h13, 20, 1'b0, nb);
        chk(!kb_err && !par_err && m_rx == {5'h13, ~^5'h13}, "R3 late ready accepted",
            int'(m_rx), int'({5'h13, ~^5'h13}));
        repeat (3) @(negedge clk);

        // R2 start while busy ignored
        xfer(5'h06, -1, 1'b1, nb);
        chk(m_rx == {5'h06, ~^5'h06}, "R2 start while busy ignored",
            int'(m_rx), int'({5'h06, ~^5'h06}));
        chk(nb == FULL, "R2 no restart", nb, FULL);
        repeat (3) @(negedge clk);
        chk(!busy, "R2 idle after ignored start", busy, 0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog R8 actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule